// File: doc/BRIEF.md
# Bidirectional DSP/CPU Mailbox Pair

This block carries short messages between a host processor and a signal processor through two 32-bit mailboxes. The outbound mailbox (index 0) carries mail from the DSP to the CPU. The inbound mailbox (index 1) carries mail from the CPU to the DSP. Each mailbox has a 16-bit high half and a 16-bit low half. The top bit of the high half is the pending flag. A sender writes the high half first and then the low half. The low-half write commits the message and raises the flag. The receiver reads the high half, which leaves state untouched. It then reads the low half, and that read acknowledges the message by dropping the flag.

Both processors reach both mailboxes. The DSP side uses an 8-bit register address. The CPU side selects a mailbox and a half. A separate peek path returns either mailbox as one 32-bit word with no side effect. A DSP write to the request register produces a one-cycle interrupt pulse toward the CPU.

Both register ports accept one access per cycle, and their read data is combinational. The ports have no ready signal and no back-pressure, so every access with its request high completes in that same cycle.

Top module: `mbox_bridge`

## Requirements
- R1: After reset, every mailbox half reads zero, both pending outputs are low, and no interrupt or invalid-request pulse is present.
- R2: A write to a high half stores bits 14:0 of the data and forces bit 15, the pending flag, to zero. A high-half write alone therefore never marks mail pending and clears any flag that was set.
- R3: A write to a low half stores all 16 bits and sets the pending flag of the same mailbox.
- R4: A read of a low half returns the stored low value and clears the pending flag of that mailbox.
- R5: A read of a high half returns {flag, bits 14:0} and changes no state.
- R6: On the DSP port, 0xFC is the outbound high half, 0xFD the outbound low half, 0xFE the inbound high half and 0xFF the inbound low half. Any other address except 0xFB reads as zero, and a write to it has no effect.
- R7: On the CPU port, cpu_box=0 selects the outbound mailbox and cpu_box=1 the inbound one. cpu_hi=1 selects the high half and cpu_hi=0 the low half.
- R8: peek_data returns {high half with flag, low half} of the mailbox chosen by peek_box. It has no side effect.
- R9: Within one cycle, writes take effect before reads. A read of a half returns the value that half holds after the same cycle's writes. When a low-half read and a low-half write meet in one cycle, the flag stays set.
- R10: When both ports write the same half in one cycle, the DSP port's data is stored.
- R11: out_pending and in_pending always equal the pending flags of the outbound and inbound mailboxes.
- R12: A DSP write to 0xFB with bit 0 set makes irq_pulse high for exactly the next cycle. The same write with bit 0 clear pulses irq_bad instead. The two pulses never coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dsp_req | input | 1 | DSP register access this cycle |
| dsp_we | input | 1 | DSP access is a write |
| dsp_addr | input | 8 | DSP register address |
| dsp_wdata | input | 16 | DSP write data |
| dsp_rdata | output | 16 | DSP read data (combinational) |
| cpu_req | input | 1 | CPU mailbox access this cycle |
| cpu_we | input | 1 | CPU access is a write |
| cpu_box | input | 1 | Mailbox select: 0 outbound, 1 inbound |
| cpu_hi | input | 1 | Half select: 1 high, 0 low |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rdata | output | 16 | CPU read data (combinational) |
| peek_box | input | 1 | Mailbox chosen for the peek path |
| peek_data | output | 32 | Side-effect-free {high, low} view |
| out_pending | output | 1 | Outbound mail pending flag |
| in_pending | output | 1 | Inbound mail pending flag |
| irq_pulse | output | 1 | One-cycle interrupt request toward the CPU |
| irq_bad | output | 1 | One-cycle flag for a request written with bit 0 clear |

## Verification
The embedded properties check the flag's life cycle on every cycle. A low-half write always leaves the flag set. A lone high-half write or low-half read always leaves it clear. An idle cycle leaves the whole mailbox unchanged. At most one DSP decode strobe is active at a time, and the interrupt pulse and the invalid-request pulse never coincide. Some behaviour only the bench's scenarios can show: the exact address and select mapping, the read values under write-first ordering, the DSP port winning a double write, and the data seen through the peek path. The bench compares all of these against a model built from the requirements, over a long sweep of mixed two-port traffic.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int HALF_W  = 16;
  localparam int DSP_AW  = 8;
  localparam int NUM_BOX = 2;

  // DSP register map: request register, then hi/lo pairs per mailbox
  localparam logic [DSP_AW-1:0] REQ_ADDR  = 8'hFB;
  localparam logic [DSP_AW-1:0] BOX_BASE  = 8'hFC;

  typedef enum logic {
    BOX_OUT = 1'b0,   // DSP -> CPU
    BOX_IN  = 1'b1    // CPU -> DSP
  } box_e;

  typedef struct packed {
    logic rd_hi;
    logic rd_lo;
    logic wr_hi;
    logic wr_lo;
  } acc_t;
endpackage

// File: rtl/mbox_slot.sv
module mbox_slot
  import mbox_pkg::*;
#(
  parameter int W = HALF_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  acc_t           pri_acc,    // priority port (DSP)
  input  logic [W-1:0]   pri_wdata,
  input  acc_t           sec_acc,    // secondary port (CPU)
  input  logic [W-1:0]   sec_wdata,
  output logic [W-1:0]   hi_view,
  output logic [W-1:0]   lo_view,
  output logic [2*W-1:0] peek,
  output logic           pending
);
  localparam int BODY_W = W - 1;

  logic [BODY_W-1:0] hi_q;
  logic [W-1:0]      lo_q;
  logic              flag_q;

  logic wr_lo, wr_hi, rd_lo;
  logic [W-1:0] lo_wval, hi_wval;
  logic [W-1:0] lo_after;
  logic [BODY_W-1:0] hi_after;
  logic flag_after;

  always_comb begin
    wr_lo   = pri_acc.wr_lo | sec_acc.wr_lo;
    wr_hi   = pri_acc.wr_hi | sec_acc.wr_hi;
    rd_lo   = pri_acc.rd_lo | sec_acc.rd_lo;
    lo_wval = pri_acc.wr_lo ? pri_wdata : sec_wdata;
    hi_wval = pri_acc.wr_hi ? pri_wdata : sec_wdata;
    lo_after   = wr_lo ? lo_wval : lo_q;
    hi_after   = wr_hi ? hi_wval[BODY_W-1:0] : hi_q;
    flag_after = wr_lo ? 1'b1 : (wr_hi ? 1'b0 : flag_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      lo_q   <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_lo) lo_q <= lo_wval;
      if (wr_hi) hi_q <= hi_wval[BODY_W-1:0];
      if (wr_lo)              flag_q <= 1'b1;
      else if (wr_hi || rd_lo) flag_q <= 1'b0;
    end
  end

  assign hi_view = {flag_after, hi_after};
  assign lo_view = lo_after;
  assign peek    = {flag_q, hi_q, lo_q};
  assign pending = flag_q;

  // R3
  commit_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> pending);
  // R2
  hi_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_lo) |=> (!pending && peek[2*W-2:W] == $past(hi_wval[BODY_W-1:0])));
  // R4
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && !wr_lo) |=> !pending);
  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_lo || wr_hi || rd_lo) |=> $stable(peek));
endmodule

// File: rtl/mbox_dsp_decode.sv
module mbox_dsp_decode
  import mbox_pkg::*;
#(
  parameter int AW   = DSP_AW,
  parameter int W    = HALF_W,
  parameter int NBOX = NUM_BOX
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req,
  input  logic                     we,
  input  logic [AW-1:0]            addr,
  input  logic [NBOX-1:0][W-1:0]   hi_view,
  input  logic [NBOX-1:0][W-1:0]   lo_view,
  output acc_t [NBOX-1:0]          acc,
  output logic                     req_fire,
  output logic [W-1:0]             rdata
);
  logic [NBOX-1:0] hit_hi, hit_lo;

  for (genvar b = 0; b < NBOX; b++) begin : g_box
    localparam logic [AW-1:0] HI_A = AW'(BOX_BASE + 2*b);
    localparam logic [AW-1:0] LO_A = AW'(BOX_BASE + 2*b + 1);
    assign hit_hi[b]   = req && (addr == HI_A);
    assign hit_lo[b]   = req && (addr == LO_A);
    assign acc[b].wr_hi = hit_hi[b] &&  we;
    assign acc[b].wr_lo = hit_lo[b] &&  we;
    assign acc[b].rd_hi = hit_hi[b] && !we;
    assign acc[b].rd_lo = hit_lo[b] && !we;
  end

  assign req_fire = req && we && (addr == REQ_ADDR);

  always_comb begin
    rdata = '0;
    for (int b = 0; b < NBOX; b++) begin
      if (hit_hi[b]) rdata = hi_view[b];
      if (hit_lo[b]) rdata = lo_view[b];
    end
  end

  // R6
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_hi, hit_lo, req_fire}));
endmodule

// File: rtl/mbox_irq_gen.sv
module mbox_irq_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic req_bit,
  output logic irq_o,
  output logic bad_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o <= 1'b0;
      bad_o <= 1'b0;
    end else begin
      irq_o <= fire &&  req_bit;
      bad_o <= fire && !req_bit;
    end
  end

  // R12
  irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_o && bad_o));
  // R12
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o || bad_o) |-> $past(fire));
endmodule

// File: rtl/mbox_bridge.sv
module mbox_bridge
  import mbox_pkg::*;
#(
  parameter int W  = HALF_W,
  parameter int AW = DSP_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dsp_req,
  input  logic          dsp_we,
  input  logic [AW-1:0] dsp_addr,
  input  logic [W-1:0]  dsp_wdata,
  output logic [W-1:0]  dsp_rdata,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic          cpu_box,
  input  logic          cpu_hi,
  input  logic [W-1:0]  cpu_wdata,
  output logic [W-1:0]  cpu_rdata,
  input  logic          peek_box,
  output logic [2*W-1:0] peek_data,
  output logic          out_pending,
  output logic          in_pending,
  output logic          irq_pulse,
  output logic          irq_bad
);
  localparam int NBOX = NUM_BOX;

  acc_t [NBOX-1:0]          dacc, cacc;
  logic [NBOX-1:0][W-1:0]   hv, lv;
  logic [NBOX-1:0][2*W-1:0] pk;
  logic [NBOX-1:0]          pend;
  logic                     fire;

  mbox_dsp_decode #(.AW(AW), .W(W), .NBOX(NBOX)) u_dec (
    .clk(clk), .rst_n(rst_n),
    .req(dsp_req), .we(dsp_we), .addr(dsp_addr),
    .hi_view(hv), .lo_view(lv),
    .acc(dacc), .req_fire(fire), .rdata(dsp_rdata)
  );

  for (genvar b = 0; b < NBOX; b++) begin : g_slot
    logic sel;
    assign sel = cpu_req && (cpu_box == 1'(b));
    assign cacc[b].wr_hi = sel &&  cpu_we &&  cpu_hi;
    assign cacc[b].wr_lo = sel &&  cpu_we && !cpu_hi;
    assign cacc[b].rd_hi = sel && !cpu_we &&  cpu_hi;
    assign cacc[b].rd_lo = sel && !cpu_we && !cpu_hi;

    mbox_slot #(.W(W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .pri_acc(dacc[b]), .pri_wdata(dsp_wdata),
      .sec_acc(cacc[b]), .sec_wdata(cpu_wdata),
      .hi_view(hv[b]), .lo_view(lv[b]),
      .peek(pk[b]), .pending(pend[b])
    );
  end

  assign cpu_rdata   = cpu_hi ? hv[cpu_box] : lv[cpu_box];
  assign peek_data   = pk[peek_box];
  assign out_pending = pend[BOX_OUT];
  assign in_pending  = pend[BOX_IN];

  mbox_irq_gen u_irq (
    .clk(clk), .rst_n(rst_n),
    .fire(fire), .req_bit(dsp_wdata[0]),
    .irq_o(irq_pulse), .bad_o(irq_bad)
  );
endmodule

// File: tb/mbox_bridge_test.sv
module mbox_bridge_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dsp_req = 0, dsp_we = 0, cpu_req = 0, cpu_we = 0, cpu_box = 0, cpu_hi = 0, peek_box = 0;
  logic [7:0]  dsp_addr = '0;
  logic [15:0] dsp_wdata = '0, cpu_wdata = '0, dsp_rdata, cpu_rdata;
  logic [31:0] peek_data;
  logic out_pending, in_pending, irq_pulse, irq_bad;

  int checks = 0, fails = 0;
  logic [14:0] mh [2];
  logic [15:0] ml [2];
  logic        mf [2];

  always #(CLK_P/2) clk = ~clk;

  mbox_bridge uut (
    .clk(clk), .rst_n(rst_n),
    .dsp_req(dsp_req), .dsp_we(dsp_we), .dsp_addr(dsp_addr), .dsp_wdata(dsp_wdata), .dsp_rdata(dsp_rdata),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_box(cpu_box), .cpu_hi(cpu_hi), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .peek_box(peek_box), .peek_data(peek_data),
    .out_pending(out_pending), .in_pending(in_pending), .irq_pulse(irq_pulse), .irq_bad(irq_bad)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_state(input string tag);
    for (int b = 0; b < 2; b++) begin
      peek_box = b[0];
      #1;
      chk({tag, " R8 peek"}, peek_data, {mf[b], mh[b], ml[b]});
    end
    chk({tag, " R11 out"}, {31'd0, out_pending}, {31'd0, mf[0]});
    chk({tag, " R11 in"},  {31'd0, in_pending},  {31'd0, mf[1]});
  endtask

  // one cycle of two-port traffic checked against the requirement model
  task automatic cyc(input logic dr, input logic dw, input logic [7:0] da, input logic [15:0] dd,
                     input logic cr, input logic cw, input logic cb, input logic ch,
                     input logic [15:0] cd, input string tag);
    logic [14:0] ah [2];
    logic [15:0] al [2];
    logic        af [2], wl [2], wh [2], rl [2];
    logic        dhit, dbox, dhi, exp_irq, exp_bad;
    logic [15:0] exp_d, exp_c;
    @(negedge clk);
    dsp_req = dr; dsp_we = dw; dsp_addr = da; dsp_wdata = dd;
    cpu_req = cr; cpu_we = cw; cpu_box = cb; cpu_hi = ch; cpu_wdata = cd;
    dhit = dr && (da >= 8'hFC);   // R6 map: bit1 = mailbox, bit0 = low half
    dbox = da[1];
    dhi  = !da[0];
    for (int b = 0; b < 2; b++) begin
      logic dwh, dwl, cwh, cwl;
      dwh = dhit && dw && dbox == b[0] && dhi;
      dwl = dhit && dw && dbox == b[0] && !dhi;
      cwh = cr && cw && cb == b[0] && ch;
      cwl = cr && cw && cb == b[0] && !ch;
      wh[b] = dwh || cwh;
      wl[b] = dwl || cwl;
      rl[b] = (dhit && !dw && dbox == b[0] && !dhi) || (cr && !cw && cb == b[0] && !ch);
      ah[b] = dwh ? dd[14:0] : (cwh ? cd[14:0] : mh[b]);   // R2 R10
      al[b] = dwl ? dd : (cwl ? cd : ml[b]);               // R3 R10
      af[b] = wl[b] ? 1'b1 : (wh[b] ? 1'b0 : mf[b]);       // R9
    end
    exp_d = (dhit && !dw) ? (dhi ? {af[dbox], ah[dbox]} : al[dbox]) : 16'h0;
    exp_c = ch ? {af[cb], ah[cb]} : al[cb];
    #1;
    if (dr && !dw) chk({tag, " R6 R9 dsp read"}, {16'd0, dsp_rdata}, {16'd0, exp_d});
    if (cr && !cw) chk({tag, " R7 R9 cpu read"}, {16'd0, cpu_rdata}, {16'd0, exp_c});
    exp_irq = dr && dw && da == 8'hFB && dd[0];
    exp_bad = dr && dw && da == 8'hFB && !dd[0];
    @(posedge clk);
    #1;
    dsp_req = 0; cpu_req = 0;
    for (int b = 0; b < 2; b++) begin
      mh[b] = ah[b];
      ml[b] = al[b];
      mf[b] = wl[b] ? 1'b1 : ((wh[b] || rl[b]) ? 1'b0 : mf[b]);   // R4
    end
    chk({tag, " R12 irq"}, {30'd0, irq_pulse, irq_bad}, {30'd0, exp_irq, exp_bad});
    check_state(tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int b = 0; b < 2; b++) begin mh[b] = '0; ml[b] = '0; mf[b] = 1'b0; end
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 irq", {30'd0, irq_pulse, irq_bad}, 32'd0);
    check_state("R1");
    @(negedge clk) rst_n = 1'b1;

    // R2 high write with bit 15 set stores it cleared
    cyc(1,1,8'hFC,16'hFFFF, 0,0,0,0,16'h0, "R2");
    // R5 high read has no effect
    cyc(1,0,8'hFC,16'h0,    0,0,0,0,16'h0, "R5");
    // R3 low write commits
    cyc(1,1,8'hFD,16'hA5C3, 0,0,0,0,16'h0, "R3");
    cyc(0,0,8'h0,16'h0,     1,0,0,1,16'h0, "R5 R7");
    // R4 CPU acknowledges outbound mail
    cyc(0,0,8'h0,16'h0,     1,0,0,0,16'h0, "R4 R7");
    // R7 CPU sends inbound mail, DSP receives
    cyc(0,0,8'h0,16'h0,     1,1,1,1,16'h1234, "R7");
    cyc(0,0,8'h0,16'h0,     1,1,1,0,16'h5678, "R7 R3");
    cyc(1,0,8'hFE,16'h0,    0,0,0,0,16'h0, "R6 R5");
    cyc(1,0,8'hFF,16'h0,    0,0,0,0,16'h0, "R6 R4");
    // R2 high write clears a set flag
    cyc(1,1,8'hFD,16'h0001, 0,0,0,0,16'h0, "R3");
    cyc(1,1,8'hFC,16'h8000, 0,0,0,0,16'h0, "R2");
    // R6 unmapped address: read zero, write ignored
    cyc(1,1,8'h10,16'hBEEF, 0,0,0,0,16'h0, "R6");
    cyc(1,0,8'h10,16'h0,    0,0,0,0,16'h0, "R6");
    cyc(1,0,8'hFB,16'h0,    0,0,0,0,16'h0, "R6");
    // R9 same-cycle low write (DSP) and low read (CPU): flag stays set
    cyc(1,1,8'hFD,16'h7777, 1,0,0,0,16'h0, "R9");
    // R10 both ports write same half
    cyc(1,1,8'hFF,16'hAAAA, 1,1,1,0,16'h5555, "R10");
    cyc(1,1,8'hFE,16'h0F0F, 1,1,1,1,16'hF0F0, "R10");
    // R12 interrupt request valid and invalid
    cyc(1,1,8'hFB,16'h0001, 0,0,0,0,16'h0, "R12");
    cyc(0,0,8'h0,16'h0,     0,0,0,0,16'h0, "R12");
    cyc(1,1,8'hFB,16'h0002, 0,0,0,0,16'h0, "R12");
    cyc(1,1,8'hFB,16'h0003, 0,0,0,0,16'h0, "R12");

    // near-exhaustive sweep of mixed two-port traffic
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] pick;
      logic [7:0] a;
      pick = 3'($urandom_range(0, 7));
      a = (pick >= 3'd6) ? 8'($urandom) : (8'hFA + 8'(pick));
      cyc(1'($urandom), 1'($urandom), a, 16'($urandom),
          1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 16'($urandom),
          "R9 R10 sweep");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule